// File: doc/BRIEF.md
# AXI Per-ID Ordering and Burst Monitor

This block is a passive observer for one AXI4 port. It watches the five channels and reacts only to their VALID, READY, ID, LEN, LAST and cache-attribute signals. It drives nothing back onto the bus. For every ID it keeps the write and read transactions that are still open in arrival order. Each response has to retire the oldest open entry of its ID. Each burst has to carry exactly LEN+1 beats.

When a rule is broken, a sticky bit for that rule is set in an error vector. At the same time a one-cycle pulse reports the ID of the beat that broke the rule. Only a synchronous reset clears the vector. A typical use is to instantiate the monitor next to an interconnect port during system tests and to watch the vector or the pulse.

AXI4 write data carries no ID. Each accepted write address therefore also enters a shared FIFO that holds its length and ID. The W beats are counted against the head of that FIFO. A write response is in order only when the data of its write has already ended.

Top module: `axi_order_monitor`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `err_flags` is all zero and `err_valid` is low.
- R2: The attribute field carries cache bits 3:1. Bit 0 is the modifiable bit and bits 2:1 are the two allocate bits. An AW or AR handshake whose attribute has an allocate bit set while the modifiable bit is clear sets `err_flags[2]`.
- R3: The W beats from the first beat up to the one with `w_last` are counted. The count must equal LEN+1 of the oldest write address that still awaits data. Otherwise `err_flags[1]` is set.
- R4: A B handshake on an ID with no open write sets `err_flags[3]`. A W handshake when no write address awaits data also sets `err_flags[3]` and reports ID 0.
- R5: A B handshake on an ID whose oldest open write has not yet finished its data (no `w_last` seen for it) sets `err_flags[0]`.
- R6: A read burst ending with `r_last` must carry LEN+1 beats of the oldest open read for its ID. Otherwise `err_flags[1]` is set. The oldest open read is retired either way.
- R7: While a read burst is in progress (a beat without `r_last` has been seen), an R beat with a different ID sets `err_flags[0]`.
- R8: An R handshake on an ID with no open read sets `err_flags[3]`.
- R9: A push into a per-ID queue that already holds DEPTH entries, or into a full write-data FIFO, sets `err_flags[4]`. The entry is dropped, so a later response for it counts as unexpected.
- R10: On any channel, VALID falling while READY was low in the previous cycle sets `err_flags[5]`.
- R11: `err_flags` bits are sticky until reset. `err_valid` pulses for one cycle, one cycle after the offending handshake. `err_id` carries the offending ID, and when several channels fail in the same cycle the priority is R, then B, then W, then AR, then AW.
- R12: A beat counts only in a cycle where both VALID and READY are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write address ID |
| aw_len | input | LEN_W | Write burst length minus one |
| aw_attr | input | 3 | Write cache bits 3:1 |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_last | input | 1 | Final write beat |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | input | ID_W | Write response ID |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read address ID |
| ar_len | input | LEN_W | Read burst length minus one |
| ar_attr | input | 3 | Read cache bits 3:1 |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | ID_W | Read data ID |
| r_last | input | 1 | Final read beat |
| err_flags | output | 6 | Sticky rule bits: 0 order, 1 beats, 2 attribute, 3 unexpected, 4 overflow, 5 handshake |
| err_valid | output | 1 | One-cycle error pulse |
| err_id | output | ID_W | ID of the offending beat |

## Verification
Every handshake-based result appears in the cycle after the clock edge that completes the offending handshake. This covers both the flag bit and the pulse with its ID. A VALID drop is flagged at the edge where VALID is first seen low, so it shows one cycle after the drop. The bench drives each beat on a falling edge and releases it on the next falling edge, which comes after exactly one rising edge. It samples the outputs at that same instant, when the pulse of that beat is visible and no later beat has been driven. Sweeps over attributes, lengths and IDs compare the flags against values computed from LEN and the attribute bits.

// File: rtl/axi_order_monitor.sv
module axi_order_monitor #(
  parameter int ID_W     = 4,
  parameter int LEN_W    = 8,
  parameter int DEPTH    = 4,
  parameter int WD_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aw_valid,
  input  logic             aw_ready,
  input  logic [ID_W-1:0]  aw_id,
  input  logic [LEN_W-1:0] aw_len,
  input  logic [2:0]       aw_attr,
  input  logic             w_valid,
  input  logic             w_ready,
  input  logic             w_last,
  input  logic             b_valid,
  input  logic             b_ready,
  input  logic [ID_W-1:0]  b_id,
  input  logic             ar_valid,
  input  logic             ar_ready,
  input  logic [ID_W-1:0]  ar_id,
  input  logic [LEN_W-1:0] ar_len,
  input  logic [2:0]       ar_attr,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic [ID_W-1:0]  r_id,
  input  logic             r_last,
  output logic [5:0]       err_flags,
  output logic             err_valid,
  output logic [ID_W-1:0]  err_id
);
  localparam int NID = 1 << ID_W;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PW  = $clog2(DEPTH);
  localparam int WPW = $clog2(WD_DEPTH);
  localparam int WCW = $clog2(WD_DEPTH + 1);
  localparam int E_ORDER = 0, E_BEATS = 1, E_ATTR = 2, E_UNEXP = 3, E_OVFL = 4, E_HSHK = 5;

  function automatic logic [PW-1:0] slot(input logic [PW-1:0] h, input logic [CW-1:0] c);
    int s;
    s = int'(h) + int'(c);
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  function automatic logic [WPW-1:0] wd_next(input logic [WPW-1:0] p);
    return (p == WPW'(WD_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [CW-1:0]    wq_cnt [NID];
  logic [CW-1:0]    wdone  [NID];
  logic [CW-1:0]    rq_cnt [NID];
  logic [PW-1:0]    rq_head[NID];
  logic [LEN_W-1:0] rq_len [NID][DEPTH];

  logic [LEN_W-1:0] wd_len [WD_DEPTH];
  logic [ID_W-1:0]  wd_id  [WD_DEPTH];
  logic [WPW-1:0]   wd_rd, wd_wr;
  logic [WCW-1:0]   wd_cnt;

  logic [LEN_W:0]   w_beats, r_beats;
  logic             r_busy;
  logic [ID_W-1:0]  r_cur;
  logic [4:0]       prev_v, prev_r;

  wire aw_hs = aw_valid & aw_ready;
  wire w_hs  = w_valid  & w_ready;
  wire b_hs  = b_valid  & b_ready;
  wire ar_hs = ar_valid & ar_ready;
  wire r_hs  = r_valid  & r_ready;

  wire aw_attr_bad = aw_hs && (aw_attr[2:1] != 2'b00) && !aw_attr[0];
  wire ar_attr_bad = ar_hs && (ar_attr[2:1] != 2'b00) && !ar_attr[0];

  wire aw_ovf  = aw_hs && ((wq_cnt[aw_id] == CW'(DEPTH)) || (wd_cnt == WCW'(WD_DEPTH)));
  wire aw_push = aw_hs && !aw_ovf;

  wire w_empty   = (wd_cnt == '0);
  wire w_unexp   = w_hs && w_empty;
  wire w_done    = w_hs && w_last && !w_empty;
  wire w_bad_cnt = w_done && (w_beats != {1'b0, wd_len[wd_rd]});
  wire [ID_W-1:0] w_owner = w_empty ? '0 : wd_id[wd_rd];

  wire b_empty = (wq_cnt[b_id] == '0);
  wire b_unexp = b_hs && b_empty;
  wire b_early = b_hs && !b_empty && (wdone[b_id] == '0);
  wire b_pop   = b_hs && !b_empty;

  wire ar_ovf  = ar_hs && (rq_cnt[ar_id] == CW'(DEPTH));
  wire ar_push = ar_hs && !ar_ovf;

  wire r_empty   = (rq_cnt[r_id] == '0);
  wire r_unexp   = r_hs && r_empty;
  wire r_inter   = r_hs && r_busy && (r_id != r_cur);
  wire r_done    = r_hs && r_last && !r_empty;
  wire r_bad_cnt = r_done && (r_beats != {1'b0, rq_len[r_id][rq_head[r_id]]});

  wire [4:0] cur_v = {r_valid, ar_valid, b_valid, w_valid, aw_valid};
  wire [4:0] cur_r = {r_ready, ar_ready, b_ready, w_ready, aw_ready};
  wire [4:0] drop  = prev_v & ~prev_r & ~cur_v;

  logic [5:0] ev;
  always_comb begin
    ev = '0;
    ev[E_ORDER] = b_early | r_inter;
    ev[E_BEATS] = w_bad_cnt | r_bad_cnt;
    ev[E_ATTR]  = aw_attr_bad | ar_attr_bad;
    ev[E_UNEXP] = b_unexp | r_unexp | w_unexp;
    ev[E_OVFL]  = aw_ovf | ar_ovf;
    ev[E_HSHK]  = |drop;
  end

  wire r_err  = r_unexp | r_inter | r_bad_cnt;
  wire b_err  = b_unexp | b_early;
  wire w_err  = w_unexp | w_bad_cnt;
  wire ar_err = ar_attr_bad | ar_ovf;
  wire aw_err = aw_attr_bad | aw_ovf;

  logic [ID_W-1:0] id_sel;
  always_comb begin
    if (r_err)       id_sel = r_id;
    else if (b_err)  id_sel = b_id;
    else if (w_err)  id_sel = w_owner;
    else if (ar_err) id_sel = ar_id;
    else if (aw_err) id_sel = aw_id;
    else             id_sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flags <= '0;
      err_valid <= 1'b0;
      err_id    <= '0;
      prev_v    <= '0;
      prev_r    <= '0;
    end else begin
      err_flags <= err_flags | ev;
      err_valid <= |ev;
      err_id    <= id_sel;
      prev_v    <= cur_v;
      prev_r    <= cur_r;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NID; i++) begin
      if (rst) begin
        wq_cnt[i]  <= '0;
        wdone[i]   <= '0;
        rq_cnt[i]  <= '0;
        rq_head[i] <= '0;
      end else begin
        wq_cnt[i] <= wq_cnt[i] + CW'(aw_push && aw_id == ID_W'(i))
                               - CW'(b_pop && b_id == ID_W'(i));
        wdone[i]  <= wdone[i] + CW'(w_done && w_owner == ID_W'(i))
                              - CW'(b_pop && b_id == ID_W'(i) && wdone[i] != '0);
        rq_cnt[i] <= rq_cnt[i] + CW'(ar_push && ar_id == ID_W'(i))
                               - CW'(r_done && r_id == ID_W'(i));
        if (r_done && r_id == ID_W'(i))
          rq_head[i] <= slot(rq_head[i], CW'(1));
        if (ar_push && ar_id == ID_W'(i))
          rq_len[i][slot(rq_head[i], rq_cnt[i])] <= ar_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_rd  <= '0;
      wd_wr  <= '0;
      wd_cnt <= '0;
    end else begin
      if (aw_push) begin
        wd_len[wd_wr] <= aw_len;
        wd_id[wd_wr]  <= aw_id;
        wd_wr         <= wd_next(wd_wr);
      end
      if (w_done) wd_rd <= wd_next(wd_rd);
      wd_cnt <= wd_cnt + WCW'(aw_push) - WCW'(w_done);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_beats <= '0;
      r_beats <= '0;
      r_busy  <= 1'b0;
      r_cur   <= '0;
    end else begin
      if (w_hs) w_beats <= w_last ? '0 : (&w_beats ? w_beats : w_beats + 1'b1);
      if (r_hs) begin
        r_beats <= r_last ? '0 : (&r_beats ? r_beats : r_beats + 1'b1);
        r_busy  <= !r_last;
        r_cur   <= r_id;
      end
    end
  end

  assert_attr_R2: assert property (@(posedge clk) disable iff (rst)
    (aw_valid && aw_ready && aw_attr[2:1] != 2'b00 && !aw_attr[0]) |=> err_flags[E_ATTR]);

  assert_ovfl_R9: assert property (@(posedge clk) disable iff (rst)
    (ar_valid && ar_ready && rq_cnt[ar_id] == CW'(DEPTH)) |=> err_flags[E_OVFL]);

  assert_unexp_R8: assert property (@(posedge clk) disable iff (rst)
    (r_valid && r_ready && rq_cnt[r_id] == '0) |=> err_flags[E_UNEXP]);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (err_flags & $past(err_flags)) == $past(err_flags));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    ((err_flags & ~$past(err_flags)) != '0) |-> err_valid);

  assert_pulse_flag_R11: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (err_flags != '0));
endmodule

// File: tb/axi_order_monitor_tb.sv
module axi_order_monitor_tb_top;
  localparam int ID_W = 2, LEN_W = 3, DEPTH = 2, WD_DEPTH = 4;

  logic clk = 0;
  logic rst = 1;
  logic aw_valid = 0, aw_ready = 1, w_valid = 0, w_ready = 1, w_last = 0;
  logic b_valid = 0, b_ready = 1, ar_valid = 0, ar_ready = 1, r_valid = 0, r_ready = 1, r_last = 0;
  logic [ID_W-1:0] aw_id = 0, b_id = 0, ar_id = 0, r_id = 0;
  logic [LEN_W-1:0] aw_len = 0, ar_len = 0;
  logic [2:0] aw_attr = 0, ar_attr = 0;
  logic [5:0] err_flags;
  logic err_valid;
  logic [ID_W-1:0] err_id;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  axi_order_monitor #(.ID_W(ID_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .WD_DEPTH(WD_DEPTH)) dut_i (
    .clk(clk), .rst(rst),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len), .aw_attr(aw_attr),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len), .ar_attr(ar_attr),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_last(r_last),
    .err_flags(err_flags), .err_valid(err_valid), .err_id(err_id));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic aw(input int id, input int len, input int attr);
    @(negedge clk); aw_valid = 1; aw_id = ID_W'(id); aw_len = LEN_W'(len); aw_attr = 3'(attr);
    @(negedge clk); aw_valid = 0;
  endtask

  task automatic ar(input int id, input int len, input int attr);
    @(negedge clk); ar_valid = 1; ar_id = ID_W'(id); ar_len = LEN_W'(len); ar_attr = 3'(attr);
    @(negedge clk); ar_valid = 0;
  endtask

  task automatic wb(input bit last);
    @(negedge clk); w_valid = 1; w_last = last;
    @(negedge clk); w_valid = 0; w_last = 0;
  endtask

  task automatic bb(input int id);
    @(negedge clk); b_valid = 1; b_id = ID_W'(id);
    @(negedge clk); b_valid = 0;
  endtask

  task automatic rb(input int id, input bit last);
    @(negedge clk); r_valid = 1; r_id = ID_W'(id); r_last = last;
    @(negedge clk); r_valid = 0; r_last = 0;
  endtask

  task automatic w_burst(input int n);
    for (int k = 0; k < n; k++) wb(k == n - 1);
  endtask

  task automatic r_burst(input int id, input int n);
    for (int k = 0; k < n; k++) rb(id, k == n - 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 flags after reset", err_flags, 0);
    check("R1 pulse after reset", err_valid, 0);

    // R2: attribute sweep on both address channels
    for (int a = 0; a < 8; a++) begin
      int e;
      e = ((a >> 1) != 0 && (a & 1) == 0) ? 1 : 0;
      do_reset();
      aw(1, 0, a);
      check("R2 aw attr flag", err_flags[2], e);
      check("R2 aw attr pulse", err_valid, e);
      if (e == 1) check("R2 aw attr id", err_id, 1);
      do_reset();
      ar(2, 0, a);
      check("R2 ar attr flag", err_flags[2], e);
      if (e == 1) check("R2 ar attr id", err_id, 2);
    end

    // R3 / R5: write beat count sweep, then response after data
    for (int id = 0; id < 4; id++)
      for (int len = 0; len < 4; len++)
        for (int d = -1; d <= 1; d++) begin
          int n, e;
          n = len + 1 + d;
          if (n == 0) continue;
          e = (d != 0) ? 1 : 0;
          do_reset();
          aw(id, len, 1);
          w_burst(n);
          check("R3 write beats flag", err_flags[1], e);
          check("R3 write beats pulse", err_valid, e);
          if (e == 1) check("R3 write beats id", err_id, id);
          bb(id);
          check("R5 in-order response", err_flags, e * 2);
        end

    // R6: read beat count sweep
    for (int len = 0; len < 4; len++)
      for (int d = -1; d <= 1; d++) begin
        int n, e;
        n = len + 1 + d;
        if (n == 0) continue;
        e = (d != 0) ? 1 : 0;
        do_reset();
        ar(3, len, 1);
        r_burst(3, n);
        check("R6 read beats flag", err_flags, e * 2);
        if (e == 1) check("R6 read beats id", err_id, 3);
      end

    // R6: oldest open read retires first
    do_reset();
    ar(1, 0, 0); ar(1, 2, 0);
    r_burst(1, 1); r_burst(1, 3);
    check("R6 in-order retire", err_flags, 0);
    do_reset();
    ar(1, 0, 0); ar(1, 2, 0);
    r_burst(1, 3);
    check("R6 reversed retire", err_flags, 2);

    // R5: response before data
    do_reset();
    aw(2, 1, 0);
    bb(2);
    check("R5 early response flag", err_flags, 1);
    check("R5 early response id", err_id, 2);

    // R4: unexpected write response and data
    do_reset();
    bb(3);
    check("R4 empty response flag", err_flags, 8);
    check("R4 empty response id", err_id, 3);
    do_reset();
    wb(1);
    check("R4 orphan data flag", err_flags, 8);
    check("R4 orphan data id", err_id, 0);

    // R8: unexpected read data
    do_reset();
    rb(2, 1);
    check("R8 empty read flag", err_flags, 8);
    check("R8 empty read id", err_id, 2);

    // R7: interleaved read ids
    do_reset();
    ar(0, 1, 0); ar(1, 1, 0);
    rb(0, 0);
    rb(1, 0);
    check("R7 interleave flag", err_flags[0], 1);
    check("R7 interleave id", err_id, 1);

    // R9: overflow drops the entry
    do_reset();
    ar(1, 0, 0); ar(1, 0, 0);
    check("R9 full no overflow", err_flags, 0);
    ar(1, 0, 0);
    check("R9 read overflow flag", err_flags, 16);
    check("R9 read overflow id", err_id, 1);
    rb(1, 1); rb(1, 1);
    check("R9 stored entries retire", err_flags, 16);
    rb(1, 1);
    check("R9 dropped entry", err_flags, 24);
    do_reset();
    aw(0, 0, 0); aw(0, 0, 0); aw(0, 0, 0);
    check("R9 write overflow flag", err_flags, 16);

    // R10: VALID drop without READY
    do_reset();
    @(negedge clk); aw_ready = 0; aw_valid = 1; aw_id = 0; aw_len = 0; aw_attr = 0;
    @(negedge clk); aw_valid = 0;
    @(negedge clk); aw_ready = 1;
    check("R10 drop flag", err_flags, 32);
    do_reset();
    @(negedge clk); aw_ready = 0; aw_valid = 1;
    @(negedge clk); aw_ready = 1;
    @(negedge clk); aw_valid = 0;
    @(negedge clk);
    check("R10 held valid", err_flags, 0);

    // R12: stalled beats do not count
    do_reset();
    ar(0, 1, 0);
    @(negedge clk); r_valid = 1; r_ready = 0; r_id = 0; r_last = 0;
    repeat (2) @(negedge clk);
    r_ready = 1;
    @(negedge clk); r_last = 1;
    @(negedge clk); r_valid = 0; r_last = 0;
    check("R12 stall not counted", err_flags, 0);

    // R11: sticky flags and single pulse
    do_reset();
    bb(0);
    check("R11 pulse set", err_valid, 1);
    @(negedge clk);
    check("R11 pulse one cycle", err_valid, 0);
    aw(1, 0, 1); w_burst(1); bb(1);
    check("R11 sticky", err_flags, 8);

    // R11: priority of R over B
    do_reset();
    @(negedge clk); b_valid = 1; b_id = 1; r_valid = 1; r_id = 2; r_last = 1;
    @(negedge clk); b_valid = 0; r_valid = 0; r_last = 0;
    check("R11 priority id", err_id, 2);
    check("R11 priority flag", err_flags, 8);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule